// File: doc/BRIEF.md
# Program Suspend and Resume Controller

This controller sits beside a flash program engine and lets the host pause a running program so that the array, status, identifier or query data can be read. It then lets the host restart the program from where it stopped. Commands arrive already decoded, as a valid strobe with a three-bit operation code. A pause asked for by the host is not applied at once. The controller raises a request toward the engine and waits until the engine reports that it has reached one of its safe stopping points.

While the program is paused, the controller drops every command except the four read selections and resume. Status data stays selected until the host chooses another read source. A program may also be started while an erase is already parked in its own suspended state. Such a program can itself be paused and resumed. When it finishes, the controller goes back to the parked-erase condition and not to plain idle. Chip enable high blocks commands and, in any ready state, signals standby. The asynchronous reset returns the controller to idle from any state.

Top module: `pss_ctrl`

## Requirements
- R1: After reset, sr7=1, sr2=0, rd_mode=0 (array), and eng_start, eng_susp_req, eng_freeze, standby and ers_parked are all 0.
- R2: cmd_op=4 (program), given while idle or while parked, pulses eng_start high for exactly one cycle. It also drops sr7 to 0 and sets rd_mode=1 (status), all on the cycle after the command.
- R3: cmd_op=5 (suspend) given while a program runs raises eng_susp_req on the next cycle, and sr2 stays 0. Only on the cycle after eng_safe is seen does the controller become suspended, shown as sr7=1, sr2=1 and eng_freeze=1.
- R4: From the program command onwards, rd_mode stays at 1 (status): through the run, the suspend request and entry to suspend. Read commands given during the run are dropped.
- R5: In any ready state, a read command sets rd_mode on the next cycle: cmd_op 0 gives array (0), 1 gives status (1), 2 gives identifier (2) and 3 gives query (3). Array data is selected only through cmd_op=0.
- R6: While suspended, cmd_op 4, 5 and 7 (other) have no effect. No eng_start pulse is produced, sr7 and sr2 stay at 1, and rd_mode is unchanged.
- R7: cmd_op=6 (resume) while suspended clears sr2 and sr7, drops eng_freeze and sets rd_mode to 1 on the next cycle.
- R8: A suspend command while idle leaves sr2=0, eng_susp_req=0 and rd_mode unchanged.
- R9: While ce_n=1 every command is ignored and the suspend state is kept. standby equals 1 when ce_n=1 and sr7=1.
- R10: Asserting rst_n low at any time, including during a suspend, returns the outputs to the R1 values at once.
- R11: A program started while erase_susp=1 (ers_parked=1) can be suspended and resumed. When eng_done arrives, the controller returns to ers_parked=1, not to idle. It leaves the parked state once erase_susp falls.
- R12: When eng_done arrives in the same cycle as a suspend command or as eng_safe, completion wins. The next cycle shows sr7=1, sr2=0 and eng_susp_req=0.
- R13: eng_done while the program runs returns the controller to a ready state with sr7=1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 3 | Command code: 0 array, 1 status, 2 id, 3 query, 4 program, 5 suspend, 6 resume, 7 other |
| erase_susp | input | 1 | An erase is parked in suspend |
| eng_safe | input | 1 | Program engine is at a safe stopping point |
| eng_done | input | 1 | Program engine has finished |
| eng_start | output | 1 | One-cycle start pulse to the program engine |
| eng_susp_req | output | 1 | Suspend request waiting for a safe point |
| eng_freeze | output | 1 | Holds the program engine while suspended |
| sr7 | output | 1 | Ready status bit |
| sr2 | output | 1 | Program-suspended status bit |
| rd_mode | output | 2 | Read source: 0 array, 1 status, 2 id, 3 query |
| standby | output | 1 | Deselected while ready |
| ers_parked | output | 1 | Controller is resting in the parked-erase condition |

## Verification
Two events can fall on the same edge: the engine's completion report, and either a host suspend command or the engine's own safe-point report. The bench provokes both cases. In one, it raises eng_done in the cycle that carries the suspend command. In the other, it raises eng_safe and eng_done together while a request is pending. In both cases it judges the next cycle by requiring a ready state with sr2 low and no request outstanding.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int OP_W = 3;
  localparam int RM_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_RD_ARRAY  = 3'd0,
    OP_RD_STATUS = 3'd1,
    OP_RD_ID     = 3'd2,
    OP_RD_QUERY  = 3'd3,
    OP_PROGRAM   = 3'd4,
    OP_SUSPEND   = 3'd5,
    OP_RESUME    = 3'd6,
    OP_OTHER     = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ERS_HOLD = 3'd1,
    ST_PROG     = 3'd2,
    ST_SREQ     = 3'd3,
    ST_PSUSP    = 3'd4
  } st_e;

  typedef enum logic [RM_W-1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_ID     = 2'd2,
    RM_QUERY  = 2'd3
  } rmode_e;

  typedef struct packed {
    logic   prog;
    logic   susp;
    logic   resume;
    logic   rd;
    rmode_e rd_sel;
  } go_t;
endpackage

// File: rtl/pss_rst_sync.sv
module pss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/pss_cmd_filter.sv
module pss_cmd_filter
  import pss_pkg::*;
(
  input  logic            ce_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  st_e             state,
  output go_t             go
);
  logic sel;
  logic ready;
  logic startable;
  op_e  op;

  always_comb begin
    op        = op_e'(cmd_op);
    sel       = cmd_valid && !ce_n;
    startable = (state == ST_IDLE) || (state == ST_ERS_HOLD);
    ready     = startable || (state == ST_PSUSP);
    go        = '0;
    go.prog   = sel && startable && (op == OP_PROGRAM);
    go.susp   = sel && (state == ST_PROG) && (op == OP_SUSPEND);
    go.resume = sel && (state == ST_PSUSP) && (op == OP_RESUME);
    go.rd     = sel && ready && !cmd_op[OP_W-1];
    go.rd_sel = rmode_e'(cmd_op[RM_W-1:0]);
  end
endmodule

// File: rtl/pss_fsm.sv
module pss_fsm
  import pss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  go_t  go,
  input  logic erase_susp,
  input  logic eng_safe,
  input  logic eng_done,
  output st_e  state,
  output logic start_pulse
);
  st_e  st_q, st_d;
  logic nest_q, nest_d;
  logic start_d;
  st_e  base;

  always_comb begin
    base    = nest_q ? ST_ERS_HOLD : ST_IDLE;
    st_d    = st_q;
    nest_d  = nest_q;
    start_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go.prog) begin
          st_d    = ST_PROG;
          nest_d  = 1'b0;
          start_d = 1'b1;
        end else if (erase_susp) begin
          st_d = ST_ERS_HOLD;
        end
      end
      ST_ERS_HOLD: begin
        if (go.prog) begin
          st_d    = ST_PROG;
          nest_d  = 1'b1;
          start_d = 1'b1;
        end else if (!erase_susp) begin
          st_d = ST_IDLE;
        end
      end
      ST_PROG: begin
        if (eng_done)     st_d = base;
        else if (go.susp) st_d = ST_SREQ;
      end
      ST_SREQ: begin
        if (eng_done)      st_d = base;
        else if (eng_safe) st_d = ST_PSUSP;
      end
      ST_PSUSP: begin
        if (go.resume) st_d = ST_PROG;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      nest_q  <= 1'b0;
      start_pulse <= 1'b0;
    end else begin
      st_q        <= st_d;
      nest_q      <= nest_d;
      start_pulse <= start_d;
    end
  end

  assign state = st_q;
endmodule

// File: rtl/pss_rdmode.sv
module pss_rdmode
  import pss_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  go_t    go,
  output rmode_e rd_mode
);
  rmode_e rm_q, rm_d;
  logic   rm_en;

  always_comb begin
    rm_en = go.prog || go.susp || go.resume || go.rd;
    rm_d  = (go.prog || go.susp || go.resume) ? RM_STATUS : go.rd_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rm_q <= RM_ARRAY;
    else if (rm_en) rm_q <= rm_d;
  end

  assign rd_mode = rm_q;
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            erase_susp,
  input  logic            eng_safe,
  input  logic            eng_done,
  output logic            eng_start,
  output logic            eng_susp_req,
  output logic            eng_freeze,
  output logic            sr7,
  output logic            sr2,
  output logic [RM_W-1:0] rd_mode,
  output logic            standby,
  output logic            ers_parked
);
  logic   rst_int_n;
  go_t    go;
  st_e    state;
  rmode_e rm;

  pss_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  pss_cmd_filter u_filt (
    .ce_n(ce_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .state(state), .go(go)
  );

  pss_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n), .go(go), .erase_susp(erase_susp),
    .eng_safe(eng_safe), .eng_done(eng_done),
    .state(state), .start_pulse(eng_start)
  );

  pss_rdmode u_rm (
    .clk(clk), .rst_n(rst_int_n), .go(go), .rd_mode(rm)
  );

  always_comb begin
    sr7          = (state == ST_IDLE) || (state == ST_ERS_HOLD) || (state == ST_PSUSP);
    sr2          = (state == ST_PSUSP);
    eng_freeze   = (state == ST_PSUSP);
    eng_susp_req = (state == ST_SREQ);
    ers_parked   = (state == ST_ERS_HOLD);
    standby      = ce_n && sr7;
    rd_mode      = rm;
  end
endmodule

// File: rtl/pss_ctrl_chk.sv
module pss_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       eng_safe,
  input logic       eng_done,
  input logic       eng_start,
  input logic       eng_susp_req,
  input logic       sr7,
  input logic       sr2,
  input logic [1:0] rd_mode
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_suspend_at_safe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr2) |-> ($past(eng_susp_req) && $past(eng_safe) && !$past(eng_done)));

  assert_status_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr2) |-> (rd_mode == 2'd1));

  assert_blocked_in_susp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr2 && cmd_valid && !ce_n && (cmd_op == 3'd4 || cmd_op == 3'd5 || cmd_op == 3'd7))
      |=> (sr2 && sr7 && !eng_start && $stable(rd_mode)));

  assert_resume_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr2 && cmd_valid && !ce_n && cmd_op == 3'd6) |=> (!sr2 && !sr7));

  assert_idle_suspend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr7 && !sr2 && cmd_valid && cmd_op == 3'd5) |=> (!sr2 && !eng_susp_req));

  assert_deselect_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> ($stable(rd_mode) && !eng_start));

  assert_done_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !sr7) |=> (sr7 && !sr2 && !eng_susp_req));
endmodule

bind pss_ctrl pss_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_int_n), .ce_n(ce_n), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .eng_safe(eng_safe), .eng_done(eng_done),
  .eng_start(eng_start), .eng_susp_req(eng_susp_req),
  .sr7(sr7), .sr2(sr2), .rd_mode(rd_mode)
);

// File: tb/pss_ctrl_test.sv
module pss_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       erase_susp = 1'b0;
  logic       eng_safe = 1'b0;
  logic       eng_done = 1'b0;
  logic       eng_start, eng_susp_req, eng_freeze, sr7, sr2, standby, ers_parked;
  logic [1:0] rd_mode;

  int vectors = 0;
  int misses = 0;
  bit finished = 1'b0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pss_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .erase_susp(erase_susp), .eng_safe(eng_safe),
    .eng_done(eng_done), .eng_start(eng_start), .eng_susp_req(eng_susp_req),
    .eng_freeze(eng_freeze), .sr7(sr7), .sr2(sr2), .rd_mode(rd_mode),
    .standby(standby), .ers_parked(ers_parked)
  );

  // observed vector: sr7 sr2 rd_mode[1:0] standby freeze start susp_req parked
  function automatic logic [8:0] obs();
    return {sr7, sr2, rd_mode, standby, eng_freeze, eng_start, eng_susp_req, ers_parked};
  endfunction

  task automatic compare(input logic [8:0] e, input string tag);
    vectors++;
    if (obs() !== e) begin
      misses++;
      $display("FAIL %s: got %b expected %b", tag, obs(), e);
    end
  endtask

  // driver: apply inputs for one cycle and queue the outputs expected after the edge
  task automatic step(input logic cen, input logic v, input logic [2:0] op,
                      input logic es, input logic sf, input logic dn,
                      input logic [8:0] e, input string tag);
    @(negedge clk);
    ce_n = cen; cmd_valid = v; cmd_op = op;
    erase_susp = es; eng_safe = sf; eng_done = dn;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: sample just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    ce_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0;
    erase_susp = 1'b0; eng_safe = 1'b0; eng_done = 1'b0;
    #0.5 rst_n = 1'b0;
    #0.5 compare(9'b1_0_00_0_0_0_0_0, tag);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset("R1 reset");
    step(0,0,0,0,0,0, 9'b1_0_00_0_0_0_0_0, "R1 idle after reset");
    step(0,1,5,0,0,0, 9'b1_0_00_0_0_0_0_0, "R8 suspend while idle");
    step(0,1,2,0,0,0, 9'b1_0_10_0_0_0_0_0, "R5 read id idle");
    step(0,1,4,0,0,0, 9'b0_0_01_0_0_1_0_0, "R2 program start");
    step(0,0,0,0,0,0, 9'b0_0_01_0_0_0_0_0, "R2 start single pulse");
    step(0,1,0,0,0,0, 9'b0_0_01_0_0_0_0_0, "R4 read during run dropped");
    step(0,1,5,0,0,0, 9'b0_0_01_0_0_0_1_0, "R3 suspend request");
    step(0,0,0,0,0,0, 9'b0_0_01_0_0_0_1_0, "R3 wait for safe point");
    step(0,0,0,0,1,0, 9'b1_1_01_0_1_0_0_0, "R3 R4 suspended at safe point");
    step(0,1,4,0,0,0, 9'b1_1_01_0_1_0_0_0, "R6 program ignored");
    step(0,1,7,0,0,0, 9'b1_1_01_0_1_0_0_0, "R6 other ignored");
    step(0,1,5,0,0,0, 9'b1_1_01_0_1_0_0_0, "R6 suspend ignored");
    step(0,1,3,0,0,0, 9'b1_1_11_0_1_0_0_0, "R5 read query in suspend");
    step(0,1,0,0,0,0, 9'b1_1_00_0_1_0_0_0, "R5 read array in suspend");
    step(1,0,0,0,0,0, 9'b1_1_00_1_1_0_0_0, "R9 standby keeps suspend");
    step(1,1,6,0,0,0, 9'b1_1_00_1_1_0_0_0, "R9 resume ignored deselected");
    step(0,1,6,0,0,0, 9'b0_0_01_0_0_0_0_0, "R7 resume");
    step(0,0,0,0,0,1, 9'b1_0_01_0_0_0_0_0, "R13 done returns ready");
    step(1,0,0,0,0,0, 9'b1_0_01_1_0_0_0_0, "R9 standby idle");
    step(0,1,4,0,0,0, 9'b0_0_01_0_0_1_0_0, "R2 second start");
    step(0,0,0,0,0,0, 9'b0_0_01_0_0_0_0_0, "R2 running");
    step(0,1,5,0,0,1, 9'b1_0_01_0_0_0_0_0, "R12 done beats suspend cmd");
    step(0,1,4,0,0,0, 9'b0_0_01_0_0_1_0_0, "R2 third start");
    step(0,1,5,0,0,0, 9'b0_0_01_0_0_0_1_0, "R3 request again");
    step(0,0,0,0,1,1, 9'b1_0_01_0_0_0_0_0, "R12 done beats safe point");
    step(0,0,0,1,0,0, 9'b1_0_01_0_0_0_0_1, "R11 erase parked");
    step(0,1,4,1,0,0, 9'b0_0_01_0_0_1_0_0, "R11 nested start");
    step(0,1,5,1,0,0, 9'b0_0_01_0_0_0_1_0, "R11 nested request");
    step(0,0,0,1,1,0, 9'b1_1_01_0_1_0_0_0, "R11 nested suspended");
    step(0,1,0,1,0,0, 9'b1_1_00_0_1_0_0_0, "R11 nested read array");
    step(0,1,6,1,0,0, 9'b0_0_01_0_0_0_0_0, "R11 nested resume");
    step(0,0,0,1,0,1, 9'b1_0_01_0_0_0_0_1, "R11 back to parked erase");
    step(0,0,0,0,0,0, 9'b1_0_01_0_0_0_0_0, "R11 leave parked");
    step(0,1,4,0,0,0, 9'b0_0_01_0_0_1_0_0, "R10 start before reset");
    step(0,1,5,0,0,0, 9'b0_0_01_0_0_0_1_0, "R10 request before reset");
    step(0,0,0,0,1,0, 9'b1_1_01_0_1_0_0_0, "R10 suspended before reset");
    do_reset("R10 async reset in suspend");
    step(0,0,0,0,0,0, 9'b1_0_00_0_0_0_0_0, "R10 idle after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule